// File: doc/BRIEF.md
# SAR ADC Conversion Controller

This block is the digital side of a 10-bit successive-approximation converter. A three-bit field picks which of five events may launch a conversion: a software start strobe, one of three timer overflow pulses, or an asynchronous external start pin. Once a start is accepted, the controller spends a fixed number of cycles in a tracking phase. It then drives a trial code to an external DAC/comparator pair and decides one result bit per cycle, most significant bit first.

When the last bit is decided, the result register is loaded and the busy indication drops on the same clock edge. A sticky completion flag is raised. The new result is tested against two programmable thresholds, and a sticky window flag is raised when the result falls inside the window. Software clears each flag with a one-cycle strobe. A global enable acts as a shutdown control: while it is low, every start event is ignored and any conversion in progress is abandoned.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Bits are resolved MSB first, one per cycle. `cmp_in` = 1 means the analog input is at or above `trial_code`. The final result equals the code that a comparator with a constant analog value implies, for every value from 0 to 1023.
- R2: `busy` reads 1 from the cycle after the accepting edge for exactly TRACK_CYC + RES_W cycles (14 with the defaults). `result` changes only on the edge where `busy` falls.
- R3: `start_src` selects the start event: 3'b000 selects `sw_start`, 3'b001 selects `tmr0_ovf`, 3'b010 selects `tmr2_ovf`, 3'b011 selects `tmr1_ovf`, and 3'b100 selects a rising edge of `ext_start`. Events from sources that are not selected have no effect.
- R4: Codes 3'b101, 3'b110 and 3'b111 never start a conversion.
- R5: While `enable` is 0, start events are ignored. A conversion in progress is dropped, so `busy` reads 0 on the next cycle, `result` keeps its old value and `done_flag` is not set.
- R6: Start events that arrive while `busy` is 1 are ignored. The conversion length is unchanged, and no new conversion follows.
- R7: `ext_start` passes through a two-flop synchronizer. A conversion begins only on its rising edge, so holding the pin high yields exactly one conversion.
- R8: `done_flag` is set when a result is stored and stays set until `done_clr` is 1. If the set and the clear fall in the same cycle, the set wins.
- R9: When `thr_ge` <= `thr_le`, the result is in the window exactly when `thr_ge` <= result <= `thr_le`.
- R10: When `thr_ge` > `thr_le`, the result is in the window exactly when result >= `thr_ge` or result <= `thr_le`.
- R11: `win_flag` is set when a stored result is in the window. It stays set, even through later results that are outside the window, until `win_clr` is 1. A set in the same cycle as a clear wins.
- R12: After reset, `busy`, `done_flag`, `win_flag`, `result` and `trial_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Global enable; 0 is shutdown |
| start_src | input | 3 | Start event select code |
| sw_start | input | 1 | Software start strobe |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tmr2_ovf | input | 1 | Timer 2 overflow pulse |
| ext_start | input | 1 | Asynchronous external start pin |
| cmp_in | input | 1 | Comparator: analog >= trial_code |
| thr_ge | input | 10 | Greater-or-equal threshold |
| thr_le | input | 10 | Less-or-equal threshold |
| done_clr | input | 1 | Clear strobe for done_flag |
| win_clr | input | 1 | Clear strobe for win_flag |
| trial_code | output | 10 | Code presented to the DAC |
| busy | output | 1 | Conversion in progress |
| done_flag | output | 1 | Sticky completion flag |
| win_flag | output | 1 | Sticky window flag |
| result | output | 10 | Last stored conversion result |

## Verification
Completion of a conversion and a software clear of the done and window flags can land on the same clock edge. The bench provokes this by counting from the cycle that accepts the start and raising both clear strobes for exactly the cycle in which the last bit is decided. It then expects both flags to read 1 afterwards, since the set wins, and confirms that a later lone clear strobe does take effect. A second collision, a start event arriving in the middle of a busy conversion, is judged by the exact busy length and by `busy` staying low after the conversion ends.

// File: rtl/sar_adc_pkg.sv
// Package: shared codes for the SAR conversion controller.
// Assumes: start-source codes are fixed by the register field layout.
package sar_adc_pkg;

    // Start-event select codes (field decoded by the trigger mux)
    typedef enum logic [2:0] {
        SRC_SOFT  = 3'b000,
        SRC_TMR0  = 3'b001,
        SRC_TMR2  = 3'b010,
        SRC_TMR1  = 3'b011,
        SRC_PIN   = 3'b100
    } start_src_e;

    // Search engine phases
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TRACK = 2'd1,
        PH_SEARCH = 2'd2
    } sar_phase_e;

endpackage

// File: rtl/sar_trig_sel.sv
// Module: sar_trig_sel
// Selects one start event from a coded source field. The external pin is
// synchronized through SYNC_STAGES flops and edge-detected; timer and
// software inputs are assumed to be single-cycle synchronous pulses.
// Reserved codes yield no trigger.
module sar_trig_sel
    import sar_adc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] src_sel,
    input  logic       soft_req,
    input  logic       t0_pulse,
    input  logic       t1_pulse,
    input  logic       t2_pulse,
    input  logic       pin_async,
    output logic       trig
);

    logic [SYNC_STAGES-1:0] pin_sync;
    logic                   pin_prev;
    logic                   pin_rise;

    // Synchronizer chain for the asynchronous start pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_sync <= '0;
        end else begin
            pin_sync <= {pin_sync[SYNC_STAGES-2:0], pin_async};
        end
    end

    // Delayed copy of the synchronized pin for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_prev <= 1'b0;
        end else begin
            pin_prev <= pin_sync[SYNC_STAGES-1];
        end
    end

    assign pin_rise = pin_sync[SYNC_STAGES-1] & ~pin_prev;

    // Coded five-way start mux; reserved codes select nothing
    always_comb begin
        unique case (src_sel)
            SRC_SOFT: trig = soft_req;
            SRC_TMR0: trig = t0_pulse;
            SRC_TMR2: trig = t2_pulse;
            SRC_TMR1: trig = t1_pulse;
            SRC_PIN:  trig = pin_rise;
            default:  trig = 1'b0;
        endcase
    end

endmodule

// File: rtl/sar_search.sv
// Module: sar_search
// Successive-approximation engine. On an accepted start it tracks for
// TRACK_CYC cycles, then decides one bit per cycle, MSB first, from the
// comparator (1 = input >= trial code). On the final bit it presents the
// finished code with a one-cycle valid. Enable low returns it to idle.
module sar_search
    import sar_adc_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int TRACK_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             cmp_in,
    output logic             busy,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] fin_code,
    output logic             fin_valid
);

    localparam int CNT_W = $clog2(TRACK_CYC + 1);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(RES_W - 1);
    localparam logic [CNT_W-1:0] TRK_LAST = CNT_W'(TRACK_CYC - 1);
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    sar_phase_e       phase;
    logic [CNT_W-1:0] trk_cnt;
    logic [IDX_W-1:0] bit_idx;
    logic [IDX_W-1:0] lower_idx;
    logic [RES_W-1:0] approx;
    logic [RES_W-1:0] approx_nxt;

    assign lower_idx = bit_idx - 1'b1;

    // Decide the current bit and set the next trial bit
    always_comb begin
        approx_nxt = approx;
        if (!cmp_in) begin
            approx_nxt[bit_idx] = 1'b0;
        end
        if (bit_idx != '0) begin
            approx_nxt[lower_idx] = 1'b1;
        end
    end

    // Phase sequencing, tracking count and approximation register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            trk_cnt <= '0;
            bit_idx <= '0;
            approx  <= '0;
        end else if (!enable) begin
            phase   <= PH_IDLE;
            trk_cnt <= '0;
            bit_idx <= '0;
            approx  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_TRACK;
                        trk_cnt <= '0;
                    end
                end
                PH_TRACK: begin
                    if (trk_cnt == TRK_LAST) begin
                        phase   <= PH_SEARCH;
                        bit_idx <= TOP_IDX;
                        approx  <= MSB_ONLY;
                    end else begin
                        trk_cnt <= trk_cnt + 1'b1;
                    end
                end
                PH_SEARCH: begin
                    if (bit_idx == '0) begin
                        phase  <= PH_IDLE;
                        approx <= '0;
                    end else begin
                        approx  <= approx_nxt;
                        bit_idx <= lower_idx;
                    end
                end
                default: begin
                    phase <= PH_IDLE;
                end
            endcase
        end
    end

    assign busy      = (phase != PH_IDLE);
    assign trial     = approx;
    assign fin_code  = approx_nxt;
    assign fin_valid = enable && (phase == PH_SEARCH) && (bit_idx == '0);

endmodule

// File: rtl/sar_window.sv
// Module: sar_window
// Two-threshold window test on a finished code. With lo_thr <= hi bound
// ordering (ge <= le) the window is the inclusive range between them;
// with ge > le it is the inclusive region outside (le, ge).
module sar_window #(
    parameter int RES_W = 10
) (
    input  logic [RES_W-1:0] code,
    input  logic [RES_W-1:0] ge_thr,
    input  logic [RES_W-1:0] le_thr,
    output logic             hit
);

    logic above_ge;
    logic below_le;

    assign above_ge = (code >= ge_thr);
    assign below_le = (code <= le_thr);

    // Inside-range or outside-range decision by threshold order
    always_comb begin
        if (ge_thr <= le_thr) begin
            hit = above_ge & below_le;
        end else begin
            hit = above_ge | below_le;
        end
    end

endmodule

// File: rtl/sar_adc_ctrl.sv
// Module: sar_adc_ctrl (top)
// SAR conversion controller: start-source mux, successive-approximation
// engine, result register, window compare and sticky flags. Assumes the
// comparator settles within one clock of a trial code change and that
// the timer and software start inputs are synchronous pulses.
module sar_adc_ctrl
    import sar_adc_pkg::*;
#(
    parameter int RES_W       = 10,
    parameter int TRACK_CYC   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [2:0]       start_src,
    input  logic             sw_start,
    input  logic             tmr0_ovf,
    input  logic             tmr1_ovf,
    input  logic             tmr2_ovf,
    input  logic             ext_start,
    input  logic             cmp_in,
    input  logic [RES_W-1:0] thr_ge,
    input  logic [RES_W-1:0] thr_le,
    input  logic             done_clr,
    input  logic             win_clr,
    output logic [RES_W-1:0] trial_code,
    output logic             busy,
    output logic             done_flag,
    output logic             win_flag,
    output logic [RES_W-1:0] result
);

    logic             trig;
    logic             accept;
    logic             eng_busy;
    logic [RES_W-1:0] fin_code;
    logic             fin_valid;
    logic             win_hit;
    logic [RES_W-1:0] result_q;
    logic             done_q;
    logic             win_q;

    sar_trig_sel #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (start_src),
        .soft_req  (sw_start),
        .t0_pulse  (tmr0_ovf),
        .t1_pulse  (tmr1_ovf),
        .t2_pulse  (tmr2_ovf),
        .pin_async (ext_start),
        .trig      (trig)
    );

    assign accept = trig & enable & ~eng_busy;

    sar_search #(
        .RES_W     (RES_W),
        .TRACK_CYC (TRACK_CYC)
    ) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start     (accept),
        .cmp_in    (cmp_in),
        .busy      (eng_busy),
        .trial     (trial_code),
        .fin_code  (fin_code),
        .fin_valid (fin_valid)
    );

    sar_window #(
        .RES_W (RES_W)
    ) u_window (
        .code   (fin_code),
        .ge_thr (thr_ge),
        .le_thr (thr_le),
        .hit    (win_hit)
    );

    // Result register loads only when the last bit is decided
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
        end else if (fin_valid) begin
            result_q <= fin_code;
        end
    end

    // Sticky completion flag; completion outranks a software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (fin_valid) begin
            done_q <= 1'b1;
        end else if (done_clr) begin
            done_q <= 1'b0;
        end
    end

    // Sticky window flag; an in-window completion outranks a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
        end else if (fin_valid && win_hit) begin
            win_q <= 1'b1;
        end else if (win_clr) begin
            win_q <= 1'b0;
        end
    end

    assign busy      = eng_busy;
    assign result    = result_q;
    assign done_flag = done_q;
    assign win_flag  = win_q;

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
// Module: sar_adc_ctrl_chk
// Property checker for sar_adc_ctrl, attached by bind. Watches only the
// top-level ports; a run-length counter bounds the busy window.
module sar_adc_ctrl_chk #(
    parameter int RES_W     = 10,
    parameter int TRACK_CYC = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic [2:0]       start_src,
    input logic             busy,
    input logic             done_flag,
    input logic             done_clr,
    input logic             win_flag,
    input logic [RES_W-1:0] result
);

    localparam int RUN_MAX = TRACK_CYC + RES_W;
    localparam int RUN_W   = $clog2(RUN_MAX + 2);

    logic [RUN_W-1:0] run_len;

    // Count consecutive busy cycles, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            run_len <= '0;
        end else if (run_len != {RUN_W{1'b1}}) begin
            run_len <= run_len + 1'b1;
        end
    end

    a_r5_shutdown_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy);

    a_r4_reserved_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_src > 3'd4) |=> !busy);

    a_r2_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < RUN_W'(RUN_MAX)));

    a_r2_result_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(result));

    a_r8_done_rises_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $fell(busy));

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !done_clr) |=> done_flag);

    a_r11_win_rises_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_flag) |-> $fell(busy));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
    .RES_W     (RES_W),
    .TRACK_CYC (TRACK_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .start_src (start_src),
    .busy      (busy),
    .done_flag (done_flag),
    .done_clr  (done_clr),
    .win_flag  (win_flag),
    .result    (result)
);

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/1ps
module tb_sar_adc_ctrl;

    localparam int RES_W     = 10;
    localparam int TRACK_CYC = 4;
    localparam int CONV_LEN  = TRACK_CYC + RES_W;
    localparam int NV        = 12;
    // fields: analog[30:21], ge[20:11], le[10:1], expected window[0]
    localparam logic [30:0] VEC [NV] = '{
        {10'd100,  10'd100, 10'd200,  1'b1},
        {10'd99,   10'd100, 10'd200,  1'b0},
        {10'd200,  10'd100, 10'd200,  1'b1},
        {10'd201,  10'd100, 10'd200,  1'b0},
        {10'd800,  10'd800, 10'd100,  1'b1},
        {10'd799,  10'd800, 10'd100,  1'b0},
        {10'd100,  10'd800, 10'd100,  1'b1},
        {10'd101,  10'd800, 10'd100,  1'b0},
        {10'd0,    10'd0,   10'd1023, 1'b1},
        {10'd1023, 10'd5,   10'd5,    1'b0},
        {10'd682,  10'd300, 10'd700,  1'b1},
        {10'd341,  10'd342, 10'd1000, 1'b0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [2:0]       start_src = 3'd0;
    logic             sw_start = 1'b0;
    logic             tmr0_ovf = 1'b0;
    logic             tmr1_ovf = 1'b0;
    logic             tmr2_ovf = 1'b0;
    logic             ext_start = 1'b0;
    logic             cmp_in;
    logic [RES_W-1:0] thr_ge = '0;
    logic [RES_W-1:0] thr_le = '0;
    logic             done_clr = 1'b0;
    logic             win_clr = 1'b0;
    logic [RES_W-1:0] trial_code;
    logic             busy;
    logic             done_flag;
    logic             win_flag;
    logic [RES_W-1:0] result;
    logic [RES_W-1:0] analog = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // Behavioural comparator holding a fixed analog code
    assign cmp_in = (analog >= trial_code);

    sar_adc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start_src(start_src),
        .sw_start(sw_start), .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf),
        .tmr2_ovf(tmr2_ovf), .ext_start(ext_start), .cmp_in(cmp_in),
        .thr_ge(thr_ge), .thr_le(thr_le), .done_clr(done_clr), .win_clr(win_clr),
        .trial_code(trial_code), .busy(busy), .done_flag(done_flag),
        .win_flag(win_flag), .result(result)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One-cycle pulse on source k (0 soft, 1 tmr0, 2 tmr2, 3 tmr1, 4 pin)
    task automatic pulse_src(input int k);
        @(negedge clk);
        case (k)
            0: sw_start = 1'b1;
            1: tmr0_ovf = 1'b1;
            2: tmr2_ovf = 1'b1;
            3: tmr1_ovf = 1'b1;
            default: ext_start = 1'b1;
        endcase
        @(negedge clk);
        sw_start = 1'b0; tmr0_ovf = 1'b0; tmr1_ovf = 1'b0;
        tmr2_ovf = 1'b0; ext_start = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        done_clr = 1'b1; win_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0; win_clr = 1'b0;
    endtask

    // Count cycles until busy drops (called at negedge after acceptance)
    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Software-started conversion, returns busy length
    task automatic soft_conv(output int n);
        start_src = 3'd0;
        pulse_src(0);
        check("R2 busy after accept", int'(busy), 1);
        wait_idle(n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        int prev;
        bit saw;
        // R12: reset state
        repeat (3) @(negedge clk);
        check("R12 busy", int'(busy), 0);
        check("R12 done", int'(done_flag), 0);
        check("R12 win", int'(win_flag), 0);
        check("R12 result", int'(result), 0);
        check("R12 trial", int'(trial_code), 0);
        rst_n = 1'b1;
        enable = 1'b1;

        // R1 R2 R9 R10: vector table walk
        for (int i = 0; i < NV; i++) begin
            analog = VEC[i][30:21];
            thr_ge = VEC[i][20:11];
            thr_le = VEC[i][10:1];
            pulse_clear();
            soft_conv(n);
            check("R2 busy length", n, CONV_LEN);
            check("R1 result", int'(result), int'(VEC[i][30:21]));
            check("R8 done set", int'(done_flag), 1);
            check((VEC[i][20:11] <= VEC[i][10:1]) ? "R9 window" : "R10 window",
                  int'(win_flag), int'(VEC[i][0]));
        end

        // R3 R4: every select code against every source
        analog = 10'd321;
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 5; k++) begin
                start_src = 3'(s);
                pulse_src(k);
                saw = 0;
                repeat (4) begin
                    if (busy) saw = 1;
                    @(negedge clk);
                end
                wait_idle(n);
                repeat (2) @(negedge clk);
                check((s <= 4) ? "R3 source select" : "R4 reserved code",
                      int'(saw), (s == k) ? 1 : 0);
            end
        end

        // R7: held-high pin gives one conversion only
        start_src = 3'd4;
        @(negedge clk); ext_start = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 pin start", int'(busy), 1);
        wait_idle(n);
        saw = 0;
        repeat (20) begin
            @(negedge clk);
            if (busy) saw = 1;
        end
        check("R7 single conversion", int'(saw), 0);
        ext_start = 1'b0;
        repeat (4) @(negedge clk);

        // R6: starts during busy are ignored
        analog = 10'd555;
        start_src = 3'd0;
        pulse_src(0);
        repeat (3) @(negedge clk);
        sw_start = 1'b1; tmr0_ovf = 1'b1;
        @(negedge clk);
        sw_start = 1'b0; tmr0_ovf = 1'b0;
        wait_idle(n);
        check("R6 length unchanged", n + 4, CONV_LEN);
        saw = 0;
        repeat (6) begin
            @(negedge clk);
            if (busy) saw = 1;
        end
        check("R6 no extra conversion", int'(saw), 0);
        check("R1 result 555", int'(result), 555);

        // R5: shutdown ignores starts and aborts a conversion
        pulse_clear();
        enable = 1'b0;
        pulse_src(0);
        @(negedge clk);
        check("R5 start ignored", int'(busy), 0);
        enable = 1'b1;
        prev = int'(result);
        analog = 10'd77;
        pulse_src(0);
        repeat (5) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check("R5 abort busy", int'(busy), 0);
        check("R5 result kept", int'(result), prev);
        check("R5 no done", int'(done_flag), 0);
        enable = 1'b1;
        @(negedge clk);

        // R8 R11: clear strobes in the completion cycle
        analog = 10'd512; thr_ge = 10'd0; thr_le = 10'd1023;
        pulse_clear();
        pulse_src(0);
        repeat (CONV_LEN - 1) @(negedge clk);
        done_clr = 1'b1; win_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0; win_clr = 1'b0;
        check("R2 finished", int'(busy), 0);
        check("R8 set wins", int'(done_flag), 1);
        check("R11 set wins", int'(win_flag), 1);
        // R11: sticky through an out-of-window result
        analog = 10'd900; thr_ge = 10'd10; thr_le = 10'd20;
        soft_conv(n);
        check("R11 sticky", int'(win_flag), 1);
        @(negedge clk); done_clr = 1'b1;
        @(negedge clk); done_clr = 1'b0;
        check("R8 cleared", int'(done_flag), 0);
        check("R11 unaffected by done_clr", int'(win_flag), 1);
        @(negedge clk); win_clr = 1'b1;
        @(negedge clk); win_clr = 1'b0;
        check("R11 cleared", int'(win_flag), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule